// File: doc/BRIEF.md
# ADC Sequence Result Capture and Interrupt Flags

This block sits between an analog-to-digital converter and the processor bus for one conversion sequence. Each time the converter finishes a conversion it pulses a done strobe together with the channel number and the 12-bit result code. When that channel is part of the sequence's channel-enable mask, the block loads the result and the channel into a global data register and raises a data-valid bit there.

The sequence interrupt flag has two meanings, picked by a mode bit in the control register. In per-conversion mode the flag follows data-valid, so it rises after every accepted conversion and drops when software reads the global data register. In end-of-sequence mode the flag rises only when the highest enabled channel has been converted, and software clears it by writing a 1 to the flag bit. A single interrupt output is the flag gated by an enable bit.

Software reaches four word registers through a simple bus with write and read strobes, a 2-bit word address and 32-bit data. Read data is combinational from the current register state, and read side effects take place at the clock edge that ends the read cycle.

Top module: `adc_seq_capture`

## Requirements
- R1: A done strobe on a channel whose mask bit is 1 loads, at that clock edge, the result into global data (address 1) bits 15:4, the channel into bits 29:26, and sets data-valid at bit 31; the other bits read 0.
- R2: A read strobe at address 1 clears data-valid at the end of the read cycle; the value returned by that read still shows the pre-clear state; writes and reads of other addresses leave data-valid unchanged.
- R3: With the mode bit (control bit 30) at 0, flags bit 28 (address 2) equals data-valid, so it rises after every accepted conversion and falls after a read of address 1.
- R4: With the mode bit at 1, flags bit 28 is set only by an accepted conversion of the highest channel enabled in the mask; conversions of lower enabled channels leave it at 0.
- R5: With the mode bit at 1, writing address 2 with bit 28 at 1 clears the flag; writing it with bit 28 at 0, or reading address 1, leaves the flag set.
- R6: The interrupt output is 1 exactly when flags bit 28 is 1 and interrupt-enable bit 0 (address 3) is 1.
- R7: A done strobe on a channel whose mask bit is 0 changes neither global data nor the flag.
- R8: When a set event and a clear event reach data-valid or the end-of-sequence flag in the same cycle, the flag ends up set.
- R9: After reset, control, global data, flags and interrupt-enable all read 0 and the interrupt output is 0.
- R10: Control (address 0) holds the channel-enable mask in bits 15:0 and the mode bit in bit 30, and interrupt-enable (address 3) holds its enable in bit 0; both read back what was written in those bits and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe (triggers read side effects) |
| busAddr | input | 2 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the addressed register |
| convDone | input | 1 | One-cycle conversion-finished strobe from the converter |
| convCh | input | 4 | Channel number of the finished conversion |
| convResult | input | 12 | Result code of the finished conversion |
| irq | output | 1 | Sequence interrupt request |

## Verification
On every cycle the assertions check that an accepted conversion leaves data-valid set, that a lone read of the global data register clears it, that the end-of-sequence flag only rises after a completion strobe and holds until a write-1 clear, that a completion beats a simultaneous clear, and that the interrupt never asserts while its enable is off. Only the bench scenarios can show the register layout seen at the bus, the read returning the value before its own clear, the mirror relation in per-conversion mode, the ordering of a multi-channel sequence with its highest channel deciding completion, and that masked-off channels leave the registers untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_GDAT  = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;
  localparam logic [1:0] ADDR_INTEN = 2'd3;

  localparam int MODE_BIT     = 30;
  localparam int SEQ_FLAG_BIT = 28;
  localparam int VALID_BIT    = 31;
  localparam int CH_LSB       = 26;
  localparam int RES_LSB      = 4;
  localparam int INTEN_BIT    = 0;

  typedef struct packed {
    logic capture;   // accepted conversion: load result, set data-valid
    logic seqDone;   // end-of-sequence event in mode 1
    logic dvClear;   // bus read of the global data register
    logic seqClear;  // write-1 to the sequence flag
    logic ctrlWr;    // write to control
    logic intenWr;   // write to interrupt-enable
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              convDone,
  input  logic [CH_W-1:0]   convCh,
  input  logic [NUM_CH-1:0] chMask,
  input  logic              mode,
  output seqStrobes_t       strb
);

  logic [CH_W-1:0] highCh;
  logic            chanHit;
  logic            isLast;

  // highest enabled channel closes the sequence
  always_comb begin
    highCh = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chMask[i]) highCh = CH_W'(i);
    end
  end

  assign chanHit = chMask[convCh];
  assign isLast  = (convCh == highCh);

  always_comb begin
    strb          = '0;
    strb.capture  = convDone && chanHit;
    strb.seqDone  = convDone && chanHit && isLast && mode;
    strb.dvClear  = busRd && (busAddr == ADDR_GDAT);
    strb.seqClear = busWr && (busAddr == ADDR_FLAGS) && busWdata[SEQ_FLAG_BIT];
    strb.ctrlWr   = busWr && (busAddr == ADDR_CTRL);
    strb.intenWr  = busWr && (busAddr == ADDR_INTEN);
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CH_W-1:0]   convCh,
  input  logic [RES_W-1:0]  convResult,
  output logic [NUM_CH-1:0] chMask,
  output logic              mode,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  logic             intEn;
  logic [RES_W-1:0] resultReg;
  logic [CH_W-1:0]  resChReg;
  logic             dataValid;
  logic             seqFlagReg;
  logic             seqFlag;
  logic [DATA_W-1:0] ctrlWord, gdatWord, flagsWord, intenWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chMask <= '0;
      mode   <= 1'b0;
      intEn  <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        chMask <= busWdata[NUM_CH-1:0];
        mode   <= busWdata[MODE_BIT];
      end
      if (strb.intenWr) intEn <= busWdata[INTEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      resChReg  <= '0;
    end else if (strb.capture) begin
      resultReg <= convResult;
      resChReg  <= convCh;
    end
  end

  // set has priority over read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataValid <= 1'b0;
    else if (strb.capture)  dataValid <= 1'b1;
    else if (strb.dvClear)  dataValid <= 1'b0;
  end

  // end-of-sequence flag, set has priority over write-1 clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              seqFlagReg <= 1'b0;
    else if (strb.seqDone)  seqFlagReg <= 1'b1;
    else if (strb.seqClear) seqFlagReg <= 1'b0;
  end

  assign seqFlag = mode ? seqFlagReg : dataValid;
  assign irq     = seqFlag && intEn;

  always_comb begin
    ctrlWord                  = '0;
    ctrlWord[NUM_CH-1:0]      = chMask;
    ctrlWord[MODE_BIT]        = mode;
    gdatWord                  = '0;
    gdatWord[VALID_BIT]       = dataValid;
    gdatWord[CH_LSB +: CH_W]  = resChReg;
    gdatWord[RES_LSB +: RES_W] = resultReg;
    flagsWord                 = '0;
    flagsWord[SEQ_FLAG_BIT]   = seqFlag;
    intenWord                 = '0;
    intenWord[INTEN_BIT]      = intEn;
    unique case (busAddr)
      ADDR_CTRL:  busRdata = ctrlWord;
      ADDR_GDAT:  busRdata = gdatWord;
      ADDR_FLAGS: busRdata = flagsWord;
      default:    busRdata = intenWord;
    endcase
  end

  // R1 / R8: an accepted conversion always leaves data-valid set
  p_dv_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> dataValid);

  // R2: a read with no competing conversion clears data-valid
  p_dv_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dvClear && !strb.capture) |=> !dataValid);

  // R4: the end-of-sequence flag only rises after a completion event
  p_seq_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqFlagReg) |-> $past(strb.seqDone));

  // R5: without a write-1 clear the flag holds
  p_seq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seqFlagReg && !strb.seqClear) |=> seqFlagReg);

  // R8: completion wins over a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.seqDone && strb.seqClear) |=> seqFlagReg);

  // R6: no interrupt while the enable is off
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEn);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              convDone,
  input  logic [CH_W-1:0]   convCh,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq
);

  seqStrobes_t       strb;
  logic [NUM_CH-1:0] chMask;
  logic              mode;

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uCtrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .convDone(convDone), .convCh(convCh), .chMask(chMask), .mode(mode),
    .strb(strb)
  );

  adc_seq_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .convCh(convCh), .convResult(convResult),
    .chMask(chMask), .mode(mode), .busRdata(busRdata), .irq(irq)
  );

  // R7: a conversion on a masked-off channel is never captured
  p_mask_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !chMask[convCh]) |-> !strb.capture);

endmodule

// File: tb/adc_seq_capture_test.sv
`timescale 1ns/1ps
module adc_seq_capture_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        convDone = 1'b0;
  logic [3:0]  convCh = '0;
  logic [11:0] convResult = '0;
  logic        irq;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_capture uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .convDone(convDone),
    .convCh(convCh), .convResult(convResult), .irq(irq)
  );

  function automatic logic [31:0] gdatExp(logic v, logic [3:0] ch, logic [11:0] r);
    return {v, 1'b0, ch, 10'b0, r, 4'b0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  // side-effect-free look at a register (not address 1)
  task automatic peek(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic convert(logic [3:0] ch, logic [11:0] r);
    @(negedge clk); convDone = 1'b1; convCh = ch; convResult = r;
    @(negedge clk); convDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(2'd0, d); chk("R9 ctrl", d, 0);
    busRead(2'd1, d); chk("R9 gdat", d, 0);
    peek(2'd2, d); chk("R9 flags", d, 0);
    peek(2'd3, d); chk("R9 inten", d, 0);
    chk("R9 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWrite(2'd0, 32'hFFFF_FFFF); peek(2'd0, d);
    chk("R10 ctrl readback", d, 32'h4000_FFFF);
    busWrite(2'd3, 32'hFFFF_FFFF); peek(2'd3, d);
    chk("R10 inten readback", d, 32'h1);
    busWrite(2'd3, 0); busWrite(2'd0, 32'h0000_000D); // ch0,2,3 mode0
    peek(2'd0, d); chk("R10 ctrl mode0", d, 32'h0000_000D);
  endtask

  task automatic t_mode0();
    logic [31:0] d;
    convert(4'd2, 12'hA5C);
    peek(2'd2, d); chk("R3 flag mirrors valid", d, 32'h1000_0000);
    busWrite(2'd0, 32'h0000_000D);               // write: no clear
    busRead(2'd3, d);                            // other read: no clear
    busRead(2'd1, d); chk("R1 gdat layout", d, gdatExp(1, 4'd2, 12'hA5C));
    chk("R2 read shows pre-clear", {31'b0, d[31]}, 1);
    peek(2'd2, d); chk("R3 flag falls after read", d, 0);
    busRead(2'd1, d); chk("R2 valid cleared", d, gdatExp(0, 4'd2, 12'hA5C));
    convert(4'd0, 12'h123);
    peek(2'd2, d); chk("R3 flag rises again", d, 32'h1000_0000);
    busRead(2'd1, d); chk("R1 second capture", d, gdatExp(1, 4'd0, 12'h123));
  endtask

  task automatic t_mask();
    logic [31:0] d;
    convert(4'd7, 12'hFFF);
    busRead(2'd1, d); chk("R7 masked ch ignored", d, gdatExp(0, 4'd0, 12'h123));
    peek(2'd2, d); chk("R7 flag untouched", d, 0);
  endtask

  task automatic t_mode1();
    logic [31:0] d;
    busWrite(2'd0, 32'h4000_00A6);               // ch1,2,5,7 mode1
    convert(4'd1, 12'h011); peek(2'd2, d); chk("R4 ch1 no flag", d, 0);
    convert(4'd2, 12'h022); peek(2'd2, d); chk("R4 ch2 no flag", d, 0);
    convert(4'd5, 12'h055); peek(2'd2, d); chk("R4 ch5 no flag", d, 0);
    convert(4'd7, 12'h077); peek(2'd2, d); chk("R4 last ch sets flag", d, 32'h1000_0000);
    busRead(2'd1, d); chk("R1 mode1 valid", d, gdatExp(1, 4'd7, 12'h077));
    peek(2'd2, d); chk("R5 read keeps flag", d, 32'h1000_0000);
    busWrite(2'd2, 32'hEFFF_FFFF); peek(2'd2, d); chk("R5 write0 no effect", d, 32'h1000_0000);
    busWrite(2'd2, 32'h1000_0000); peek(2'd2, d); chk("R5 write1 clears", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    convert(4'd7, 12'h777);
    peek(2'd2, d); chk("R6 irq off while disabled", {31'b0, irq}, 0);
    busWrite(2'd3, 1); peek(2'd2, d); chk("R6 irq on", {31'b0, irq}, 1);
    busWrite(2'd2, 32'h1000_0000); peek(2'd2, d); chk("R6 irq drops with flag", {31'b0, irq}, 0);
    busWrite(2'd3, 0);
  endtask

  task automatic t_setWins();
    logic [31:0] d;
    @(negedge clk); convDone = 1'b1; convCh = 4'd7; convResult = 12'h7A7;
    busWr = 1'b1; busAddr = 2'd2; busWdata = 32'h1000_0000;
    @(negedge clk); convDone = 1'b0; busWr = 1'b0; busWdata = '0;
    peek(2'd2, d); chk("R8 seq set beats clear", d, 32'h1000_0000);
    busWrite(2'd2, 32'h1000_0000);
    busWrite(2'd0, 32'h0000_0080);               // ch7 mode0
    busRead(2'd1, d);
    @(negedge clk); convDone = 1'b1; convCh = 4'd7; convResult = 12'h3C3;
    busRd = 1'b1; busAddr = 2'd1;
    @(negedge clk); convDone = 1'b0; busRd = 1'b0;
    busRead(2'd1, d); chk("R8 valid set beats read", d, gdatExp(1, 4'd7, 12'h3C3));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_mode0();
    t_mask();
    t_mode1();
    t_irq();
    t_setWins();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule